// File: doc/BRIEF.md
# Reset and wake-up sequencer

This block decides when a small microcontroller core may run. Four reset causes feed it: power-on, an active-low reset pin, a watchdog time-out and a USB bus reset. It also takes a HALT request from the core and wake-up sources for leaving HALT: a pin-change line and a vector of interrupt request flags. Each reset is classified either as a full (cold) reset of the whole core or as a warm reset, which clears only the program counter and the stack pointer. Every reset and every wake-up is followed by a fixed start-up delay, during which the core is held stalled. While the delay runs, a level strobe of the right kind tells the core what to clear.

Two status flags are kept for software. The time-out flag shows that a watchdog expiry caused the last reset. The power-down flag shows that the core had gone into HALT. Software reads them to tell the reset causes apart. When a wake-up comes from an interrupt, a one-cycle pulse tells the core to enter the interrupt service one cycle after it starts running again. A plain wake-up resumes the program with no pulse.

Top module: `rstwake_seq`

## Requirements
- R1: While `por_i` is high, `cold_rst_o`=1, `run_en_o`=0, `to_o`=0 and `pdf_o`=0. After `por_i` falls, `cold_rst_o` stays high for exactly DELAY_CYC more samples, and then `run_en_o` rises.
- R2: Every reset cause and every wake-up from HALT is followed by exactly DELAY_CYC cycles with `run_en_o`=0 before the core runs. The count starts at the clock edge that takes the cause. Whichever strobe applies (`cold_rst_o` or `warm_rst_o`) is high for that whole window.
- R3: A reset cause that arrives while the delay is running restarts the count from zero. The stall then lasts DELAY_CYC cycles from the later cause.
- R4: A watchdog time-out while halted is a warm reset. `warm_rst_o` is high instead of `cold_rst_o`, and afterwards `to_o`=1 and `pdf_o`=1.
- R5: A watchdog time-out while running is a cold reset. It sets `to_o`=1 and leaves `pdf_o` unchanged.
- R6: The reset pin is active low and passes through a SYNC_STAGES-flop synchronizer. A pin reset while running is a cold reset that leaves both flags unchanged.
- R7: A pin reset while halted is a cold reset that sets `to_o`=0 and `pdf_o`=1.
- R8: A USB bus reset is a cold reset that leaves both flags unchanged.
- R9: When causes meet at the same clock edge, the synchronized pin wins over the watchdog, and the watchdog wins over USB reset. Only the winning cause sets the strobe type and the flags.
- R10: A HALT request while running drops `run_en_o` in the next cycle and sets `pdf_o`=1. Once set, `pdf_o` is cleared only by power-on. A HALT request that arrives while the core is not running is ignored.
- R11: An interrupt flag bit of `irq_pend_i` that is already set when HALT is entered cannot wake the core. A flag bit that rises during HALT, or a high `wake_pin_i`, starts the wake-up delay.
- R12: After an interrupt wake-up, `irq_go_o` pulses for one cycle, in the second cycle that `run_en_o` is high. A wake-up from `wake_pin_i` produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog time-out event |
| usb_rst_i | input | 1 | USB bus reset event |
| halt_req_i | input | 1 | HALT request from the core |
| wake_pin_i | input | 1 | Pin-change wake-up event |
| irq_pend_i | input | NUM_IRQ | Interrupt request flags |
| run_en_o | output | 1 | Core may execute |
| cold_rst_o | output | 1 | Full core reset, held through the delay |
| warm_rst_o | output | 1 | Program counter and stack pointer reset, held through the delay |
| irq_go_o | output | 1 | Enter interrupt service (one-cycle pulse) |
| to_o | output | 1 | Watchdog time-out status flag |
| pdf_o | output | 1 | Power-down status flag |

## Verification
Two functions can fall in the same cycle: classification of a reset pin event and classification of a watchdog or USB event. The case that matters is the pin and the watchdog together in HALT, because the result decides between a cold and a warm reset and between TO=0 and TO=1. The bench drives the pin pulse two cycles before the watchdog pulse, which covers the synchronizer latency, so both reach the classifier at the same edge. The outcome is judged by which strobe rises and by the flag values once the core is running again. A second kind of overlap is a fresh cause arriving inside a running delay. This is judged by the total stall length, which must equal the offset of the second cause plus the full delay.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_DELAY = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RK_COLD     = 2'd0,
        RK_WARM     = 2'd1,
        RK_WAKE_RES = 2'd2,
        RK_WAKE_IRQ = 2'd3
    } rst_kind_e;

    typedef struct packed {
        logic to;
        logic pdf;
    } stat_flags_t;

endpackage

// File: rtl/rstwake_pin_sync.sv
module rstwake_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic pin_ni,
    output logic asserted_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = pin_ni;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], pin_ni};
        end
    endgenerate

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= '1;
        else       chain_q <= chain_d;
    end

    assign asserted_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/rstwake_classify.sv
module rstwake_classify
    import rstwake_pkg::*;
(
    input  logic        pin_low_i,
    input  logic        wdt_i,
    input  logic        usb_i,
    input  logic        halted_i,
    input  stat_flags_t flags_i,
    output logic        hit_o,
    output rst_kind_e   kind_o,
    output stat_flags_t flags_o
);
    // Fixed priority: pin, then watchdog, then USB bus reset.
    always_comb begin
        hit_o   = 1'b0;
        kind_o  = RK_COLD;
        flags_o = flags_i;
        if (pin_low_i) begin
            hit_o = 1'b1;
            if (halted_i) begin
                flags_o.to  = 1'b0;
                flags_o.pdf = 1'b1;
            end
        end else if (wdt_i) begin
            hit_o      = 1'b1;
            flags_o.to = 1'b1;
            if (halted_i) begin
                kind_o      = RK_WARM;
                flags_o.pdf = 1'b1;
            end
        end else if (usb_i) begin
            hit_o = 1'b1;
        end
    end
endmodule

// File: rtl/rstwake_delay.sv
module rstwake_delay #(
    parameter int DELAY_CYC = 1024
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic restart_i,
    input  logic count_en_i,
    output logic done_o
);
    localparam int CW = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)                       cnt_d = '0;
        else if (count_en_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/rstwake_seq.sv
module rstwake_seq
    import rstwake_pkg::*;
#(
    parameter int DELAY_CYC   = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_IRQ     = 4
) (
    input  logic               clk_i,
    input  logic               por_i,
    input  logic               rst_pin_ni,
    input  logic               wdt_to_i,
    input  logic               usb_rst_i,
    input  logic               halt_req_i,
    input  logic               wake_pin_i,
    input  logic [NUM_IRQ-1:0] irq_pend_i,
    output logic               run_en_o,
    output logic               cold_rst_o,
    output logic               warm_rst_o,
    output logic               irq_go_o,
    output logic               to_o,
    output logic               pdf_o
);
    typedef struct packed {
        seq_state_e         state;
        rst_kind_e          kind;
        stat_flags_t        flags;
        logic [NUM_IRQ-1:0] wake_mask;
        logic               irq_arm;
        logic               irq_go;
    } seq_regs_t;

    seq_regs_t   r_d, r_q;
    logic        pin_low_w;
    logic        cls_hit_w;
    rst_kind_e   cls_kind_w;
    stat_flags_t cls_flags_w;
    logic        halted_w;
    logic        irq_wake_w;
    logic        wake_w;
    logic        restart_w;
    logic        done_w;

    rstwake_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .pin_ni     (rst_pin_ni),
        .asserted_o (pin_low_w)
    );

    assign halted_w = (r_q.state == ST_HALT);

    rstwake_classify u_classify (
        .pin_low_i (pin_low_w),
        .wdt_i     (wdt_to_i),
        .usb_i     (usb_rst_i),
        .halted_i  (halted_w),
        .flags_i   (r_q.flags),
        .hit_o     (cls_hit_w),
        .kind_o    (cls_kind_w),
        .flags_o   (cls_flags_w)
    );

    // Only request flags that were clear at HALT entry may wake the core.
    assign irq_wake_w = |(irq_pend_i & r_q.wake_mask);
    assign wake_w     = halted_w && (irq_wake_w || wake_pin_i);
    assign restart_w  = cls_hit_w || wake_w;

    rstwake_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .restart_i  (restart_w),
        .count_en_i (r_q.state == ST_DELAY),
        .done_o     (done_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.irq_go = 1'b0;
        if (cls_hit_w) begin
            r_d.state   = ST_DELAY;
            r_d.kind    = cls_kind_w;
            r_d.flags   = cls_flags_w;
            r_d.irq_arm = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_RUN: begin
                    if (r_q.irq_arm) begin
                        r_d.irq_go  = 1'b1;
                        r_d.irq_arm = 1'b0;
                    end
                    if (halt_req_i) begin
                        r_d.state     = ST_HALT;
                        r_d.flags.pdf = 1'b1;
                        r_d.wake_mask = ~irq_pend_i;
                    end
                end
                ST_HALT: begin
                    if (wake_w) begin
                        r_d.state = ST_DELAY;
                        r_d.kind  = irq_wake_w ? RK_WAKE_IRQ : RK_WAKE_RES;
                    end
                end
                ST_DELAY: begin
                    if (done_w) begin
                        r_d.state   = ST_RUN;
                        r_d.irq_arm = (r_q.kind == RK_WAKE_IRQ);
                    end
                end
                default: r_d.state = ST_DELAY;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            r_q <= '{state: ST_DELAY, kind: RK_COLD, flags: '0,
                     wake_mask: '0, irq_arm: 1'b0, irq_go: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign run_en_o   = (r_q.state == ST_RUN);
    assign cold_rst_o = (r_q.state == ST_DELAY) && (r_q.kind == RK_COLD);
    assign warm_rst_o = (r_q.state == ST_DELAY) && (r_q.kind == RK_WARM);
    assign irq_go_o   = r_q.irq_go;
    assign to_o       = r_q.flags.to;
    assign pdf_o      = r_q.flags.pdf;
endmodule

// File: rtl/rstwake_seq_chk.sv
module rstwake_seq_chk #(
    parameter int DELAY_CYC = 1024
) (
    input logic clk_i,
    input logic por_i,
    input logic pin_low_i,
    input logic wdt_to_i,
    input logic usb_rst_i,
    input logic halt_req_i,
    input logic run_en_o,
    input logic cold_rst_o,
    input logic warm_rst_o,
    input logic irq_go_o,
    input logic to_o,
    input logic pdf_o
);
    logic [31:0] win_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i)                        win_q <= '0;
        else if (cold_rst_o || warm_rst_o) win_q <= win_q + 32'd1;
        else                              win_q <= '0;
    end

    p_cold_len_r2: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(cold_rst_o) |-> (win_q >= 32'(DELAY_CYC)));

    p_warm_len_r2: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(warm_rst_o) |-> (win_q >= 32'(DELAY_CYC)));

    p_warm_flags_r4: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(warm_rst_o) |-> (to_o && pdf_o));

    p_wdt_run_cold_r5: assert property (@(posedge clk_i) disable iff (por_i)
        (run_en_o && wdt_to_i && !pin_low_i) |=> (cold_rst_o && to_o));

    p_usb_keeps_flags_r8: assert property (@(posedge clk_i) disable iff (por_i)
        (run_en_o && usb_rst_i && !pin_low_i && !wdt_to_i)
        |=> (cold_rst_o && $stable(to_o) && $stable(pdf_o)));

    p_pin_wins_r9: assert property (@(posedge clk_i) disable iff (por_i)
        pin_low_i |=> (cold_rst_o && !warm_rst_o));

    p_halt_stops_r10: assert property (@(posedge clk_i) disable iff (por_i)
        (run_en_o && halt_req_i && !pin_low_i && !wdt_to_i && !usb_rst_i)
        |=> (!run_en_o && pdf_o));

    p_pdf_sticky_r10: assert property (@(posedge clk_i) disable iff (por_i)
        pdf_o |=> pdf_o);

    p_go_after_run_r12: assert property (@(posedge clk_i) disable iff (por_i)
        irq_go_o |-> $past(run_en_o));

    p_go_single_r12: assert property (@(posedge clk_i) disable iff (por_i)
        irq_go_o |=> !irq_go_o);
endmodule

bind rstwake_seq rstwake_seq_chk #(.DELAY_CYC(DELAY_CYC)) u_seq_chk (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .pin_low_i  (pin_low_w),
    .wdt_to_i   (wdt_to_i),
    .usb_rst_i  (usb_rst_i),
    .halt_req_i (halt_req_i),
    .run_en_o   (run_en_o),
    .cold_rst_o (cold_rst_o),
    .warm_rst_o (warm_rst_o),
    .irq_go_o   (irq_go_o),
    .to_o       (to_o),
    .pdf_o      (pdf_o)
);

// File: tb/rstwake_seq_tb_top.sv
module rstwake_seq_tb_top;
    localparam int N     = 1024;
    localparam int LIMIT = 120000;
    localparam int NV    = 12;
    localparam int KOFF  = 100;

    // bits: [7] halt first [6] pin [5] wdt [4] usb [3] exp cold [2] exp warm [1] exp TO [0] exp PDF
    localparam logic [7:0] VEC [NV] = '{
        8'b0010_1010,  // run, watchdog
        8'b0001_1010,  // run, usb
        8'b1100_1001,  // halt, pin
        8'b0100_1001,  // run, pin
        8'b1010_0111,  // halt, watchdog -> warm
        8'b0100_1011,  // run, pin
        8'b1110_1001,  // halt, pin + watchdog
        8'b0011_1011,  // run, watchdog + usb
        8'b1011_0111,  // halt, watchdog + usb
        8'b0111_1011,  // run, all three
        8'b1001_1011,  // halt, usb
        8'b0101_1011   // run, pin + usb
    };

    logic       clk_i = 1'b0;
    logic       por_i = 1'b1;
    logic       rst_pin_ni = 1'b1;
    logic       wdt_to_i = 1'b0;
    logic       usb_rst_i = 1'b0;
    logic       halt_req_i = 1'b0;
    logic       wake_pin_i = 1'b0;
    logic [3:0] irq_pend_i = '0;
    logic       run_en_o, cold_rst_o, warm_rst_o, irq_go_o, to_o, pdf_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk_i = ~clk_i;

    rstwake_seq dut_i (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .rst_pin_ni (rst_pin_ni),
        .wdt_to_i   (wdt_to_i),
        .usb_rst_i  (usb_rst_i),
        .halt_req_i (halt_req_i),
        .wake_pin_i (wake_pin_i),
        .irq_pend_i (irq_pend_i),
        .run_en_o   (run_en_o),
        .cold_rst_o (cold_rst_o),
        .warm_rst_o (warm_rst_o),
        .irq_go_o   (irq_go_o),
        .to_o       (to_o),
        .pdf_o      (pdf_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pin pulse first, watchdog/usb two cycles later, so both meet the classifier at one edge.
    task automatic apply(input bit pin, input bit wdt, input bit usb);
        @(negedge clk_i); rst_pin_ni = ~pin;
        @(negedge clk_i); rst_pin_ni = 1'b1;
        @(negedge clk_i); wdt_to_i = wdt; usb_rst_i = usb;
        @(negedge clk_i); wdt_to_i = 1'b0; usb_rst_i = 1'b0;
    endtask

    task automatic do_halt();
        @(negedge clk_i); halt_req_i = 1'b1;
        @(negedge clk_i); halt_req_i = 1'b0;
        check(!run_en_o && pdf_o, "R10 halt drops run, sets PDF",
              {30'd0, run_en_o, pdf_o}, 1);
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!run_en_o && n < 5000) begin
            n++;
            @(negedge clk_i);
        end
    endtask

    initial begin
        int n;
        bit saw_cold, saw_warm;
        string req;

        // R1: power-on state
        repeat (5) @(negedge clk_i);
        check(cold_rst_o && !run_en_o, "R1 cold held during power-on",
              {30'd0, cold_rst_o, run_en_o}, 2);
        check(!to_o && !pdf_o, "R1 flags cleared by power-on", {30'd0, to_o, pdf_o}, 0);
        por_i = 1'b0;
        n = 0;
        while (cold_rst_o && n < 5000) begin
            n++;
            @(negedge clk_i);
        end
        check(n == N, "R1 cold window after power-on", n, N);
        check(run_en_o == 1'b1, "R1 core runs after delay", run_en_o, 1);

        // R10: HALT request during the delay is ignored
        apply(0, 1, 0);
        @(negedge clk_i); halt_req_i = 1'b1;
        @(negedge clk_i); halt_req_i = 1'b0;
        count_low(n);
        repeat (3) @(negedge clk_i);
        check(run_en_o && !pdf_o, "R10 halt ignored outside run",
              {30'd0, run_en_o, pdf_o}, 2);

        // R3: second cause during the delay restarts it
        apply(0, 1, 0);
        n = 0;
        while (!run_en_o && n < 5000) begin
            n++;
            if (n == KOFF)     usb_rst_i = 1'b1;
            if (n == KOFF + 1) usb_rst_i = 1'b0;
            @(negedge clk_i);
        end
        usb_rst_i = 1'b0;
        check(n == KOFF + N, "R3 restart extends stall", n, KOFF + N);

        // Vector table
        foreach (VEC[i]) begin
            logic [7:0] v;
            v = VEC[i];
            if (v[7]) do_halt();
            apply(v[6], v[5], v[4]);
            saw_cold = cold_rst_o;
            saw_warm = warm_rst_o;
            n = 0;
            while ((cold_rst_o || warm_rst_o) && n < 5000) begin
                n++;
                @(negedge clk_i);
            end
            if ((v[6] + v[5] + v[4]) > 1)  req = "R9";
            else if (v[6])                 req = v[7] ? "R7" : "R6";
            else if (v[5])                 req = v[7] ? "R4" : "R5";
            else                           req = "R8";
            check(saw_cold == v[3] && saw_warm == v[2], {req, " strobe type"},
                  {30'd0, saw_cold, saw_warm}, {30'd0, v[3], v[2]});
            check(n == N, "R2 strobe window length", n, N);
            check(to_o == v[1], {req, " TO flag"}, to_o, v[1]);
            check(pdf_o == v[0], {req, " PDF flag"}, pdf_o, v[0]);
            repeat (2) @(negedge clk_i);
        end

        // R11: flag set before HALT cannot wake
        irq_pend_i = 4'b0010;
        do_halt();
        repeat (20) @(negedge clk_i);
        check(!run_en_o && !cold_rst_o && !warm_rst_o, "R11 pending flag masked",
              {29'd0, run_en_o, cold_rst_o, warm_rst_o}, 0);
        irq_pend_i = 4'b0110;
        @(negedge clk_i);
        count_low(n);
        check(n == N, "R11 new flag wakes after delay", n, N);
        // R12: service pulse on second run cycle
        check(irq_go_o == 1'b0, "R12 no pulse on first run cycle", irq_go_o, 0);
        @(negedge clk_i);
        check(irq_go_o == 1'b1, "R12 pulse on second run cycle", irq_go_o, 1);
        @(negedge clk_i);
        check(irq_go_o == 1'b0, "R12 pulse lasts one cycle", irq_go_o, 0);
        irq_pend_i = '0;

        // R12: pin-change wake resumes without pulse
        do_halt();
        repeat (5) @(negedge clk_i);
        wake_pin_i = 1'b1;
        @(negedge clk_i); wake_pin_i = 1'b0;
        count_low(n);
        check(n == N, "R2 pin-change wake delay", n, N);
        n = 0;
        for (int k = 0; k < 4; k++) begin
            if (irq_go_o) n++;
            @(negedge clk_i);
        end
        check(n == 0, "R12 no pulse after resume wake", n, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk_i);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired: cycles=%0d expected<%0d", LIMIT, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule